// File: doc/BRIEF.md
# Memory Region CRC-32 Checker

This block answers a region-checksum request arriving as a byte stream. A request frame opens with a command byte. Eight argument bytes follow it: a 32-bit start address, then a 32-bit byte count, each sent high byte first. The input marks the final byte of the frame with `in_last`. Once the frame is accepted, the block walks the region through a synchronous memory read port. It issues one read per cycle, and the data returns one cycle later. It folds every returned byte into a reflected CRC-32.

When the last byte has been folded in, the block emits a five-byte reply on consecutive cycles: a reply code, then the CRC with its most significant byte first. A frame that carries the right command but the wrong number of argument bytes gets a one-byte error reply instead. The host compares the returned CRC with a checksum of its own image. In typical use the host asks for one whole erase block, for example 0x20000 bytes at 0x000E0000, or one of the 0x1000-byte blocks in the low 32 KiB.

Top module: `crc_region_check`

## Requirements
- R1: A frame whose first byte is 0x02 and that ends (`in_last`) on its ninth byte is accepted: bytes 2..5 form the start address and bytes 6..9 the byte count, each most significant byte first, and the CRC covers the bytes at addresses start .. start+count-1.
- R2: The reply to an accepted frame is five bytes on five consecutive cycles with `out_valid` high: 0x82, then CRC bits 31:24, 23:16, 15:8, 7:0; `out_last` is high only with the fifth byte.
- R3: The CRC is the reflected CRC-32 with polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion; the ASCII bytes "123456789" give 0xCBF43926.
- R4: A frame whose first byte is 0x02 but whose total length is not nine bytes gets a single reply byte 0xF0 with `out_last` high, and no memory read is made.
- R5: A frame whose first byte is not 0x02 produces no reply, no memory read and no `busy`.
- R6: A count of zero gives the reply 0x82 00 00 00 00 without asserting `mem_rd_en`.
- R7: For a count N, `mem_rd_en` is high for exactly N cycles in one unbroken run, and the address rises by one each cycle, wrapping from 0xFFFFFFFF to 0x00000000. Read data is taken one cycle after its read.
- R8: `busy` rises in the cycle after the final byte of an answered frame is taken. It stays high up to and including the cycle that shows the last reply byte, and it is low in the cycle after that.
- R9: Input bytes sampled while `busy` is high are ignored. A frame that begins while `busy` is high is dropped whole, even if its later bytes arrive after `busy` has fallen. This includes a frame that ends in the same cycle as the final reply byte.
- R10: During reset, `out_valid`, `mem_rd_en` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request byte present |
| in_byte | input | 8 | Request byte |
| in_last | input | 1 | Marks the final byte of a request frame |
| busy | output | 1 | Request in progress; input ignored |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | Reply byte present |
| out_byte | output | 8 | Reply byte |
| out_last | output | 1 | Marks the final reply byte |

## Verification
Two events can fall in the same cycle: the final reply byte leaving the block, and a new frame's closing byte arriving while `busy` is still high for that cycle. The bench watches for the cycle in which `out_last` shows and drives a one-byte 0x02 frame there. It holds the same byte for the following cycle as a second frame. The first frame must be dropped and the second must draw exactly one 0xF0 reply. The bench also records every cycle that follows `out_last` and requires `busy` to be low in each.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
  localparam logic [7:0]  CMD_CRC    = 8'h02;
  localparam logic [7:0]  RSP_CRC    = 8'h82;
  localparam logic [7:0]  RSP_BADLEN = 8'hF0;

  // One byte folded into a reflected CRC-32, LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                           input logic [7:0]  d_in);
    logic [31:0] c;
    c = c_in ^ {24'h0, d_in};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_req_parser.sv
module crc_req_parser
  import crc_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic              busy_i,
  output logic              start_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int ARG_W     = ADDR_W + LEN_W;
  localparam int ARG_BYTES = ARG_W / 8;
  localparam int CNT_W     = $clog2(ARG_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ARG_BYTES);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ARG_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cmd_ok_q, cmd_ok_d;
  logic             skip_q, skip_d;
  logic [ARG_W-1:0] arg_q, arg_d;
  logic             arg_en;
  logic             start_q, start_d, err_q, err_d;
  logic             take, cmd_now;

  always_comb begin
    cnt_d    = cnt_q;
    cmd_ok_d = cmd_ok_q;
    skip_d   = skip_q;
    arg_d    = arg_q;
    arg_en   = 1'b0;
    start_d  = 1'b0;
    err_d    = 1'b0;
    take     = in_valid & ~busy_i & ~skip_q;
    cmd_now  = (cnt_q == '0) ? (in_byte == CMD_CRC) : cmd_ok_q;
    if (in_valid && (busy_i || skip_q)) begin
      // drop the rest of a frame that opened while busy
      skip_d = ~in_last;
    end else if (take) begin
      if (cnt_q == '0) begin
        cmd_ok_d = (in_byte == CMD_CRC);
      end else begin
        arg_en = 1'b1;
        arg_d  = {arg_q[ARG_W-9:0], in_byte};
      end
      if (in_last) begin
        cnt_d = '0;
        if (cmd_now) begin
          if (cnt_q == CNT_FULL) start_d = 1'b1;
          else                   err_d   = 1'b1;
        end
      end else if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmd_ok_q <= 1'b0;
      skip_q   <= 1'b0;
      start_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      cmd_ok_q <= cmd_ok_d;
      skip_q   <= skip_d;
      start_q  <= start_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arg_q <= '0;
    else if (arg_en) arg_q <= arg_d;
  end

  assign start_o = start_q;
  assign err_o   = err_q;
  assign addr_o  = arg_q[ARG_W-1:LEN_W];
  assign len_o   = arg_q[LEN_W-1:0];
endmodule

// File: rtl/crc_walker.sv
module crc_walker
  import crc_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              done_o,
  output logic [31:0]       crc_o
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              vld_q, last_q, last_rd;
  logic [31:0]       crc_q, crc_d;
  logic              done_q, done_d;

  always_comb begin
    last_rd  = active_q && (remain_q == LEN_W'(1));
    active_d = active_q & ~last_rd;
    addr_d   = addr_q;
    remain_d = remain_q;
    crc_d    = crc_q;
    if (start_i) begin
      active_d = (len_i != '0);
      addr_d   = addr_i;
      remain_d = len_i;
      crc_d    = CRC_SEED;
    end else begin
      if (active_q) begin
        addr_d   = addr_q + 1'b1;
        remain_d = remain_q - 1'b1;
      end
      if (vld_q) crc_d = crc_step(crc_q, mem_rd_data_i);
    end
    done_d = (start_i && (len_i == '0)) || (vld_q && last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      crc_q    <= CRC_SEED;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      vld_q    <= active_q;
      last_q   <= last_rd;
      crc_q    <= crc_d;
      done_q   <= done_d;
    end
  end

  assign mem_rd_en_o = active_q;
  assign mem_addr_o  = addr_q;
  assign done_o      = done_q;
  assign crc_o       = ~crc_q;
endmodule

// File: rtl/crc_resp_tx.sv
module crc_resp_tx
  import crc_chk_pkg::*;
#(
  parameter int CRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_crc_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             load_err_i,
  output logic             out_valid_o,
  output logic [7:0]       out_byte_o,
  output logic             out_last_o
);
  localparam int FR_BYTES = CRC_W / 8 + 1;
  localparam int FR_W     = FR_BYTES * 8;
  localparam int CNT_W    = $clog2(FR_BYTES + 1);

  logic [FR_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load_crc_i) begin
      sh_d  = {RSP_CRC, crc_i};
      cnt_d = CNT_W'(FR_BYTES);
    end else if (load_err_i) begin
      sh_d  = {RSP_BADLEN, {CRC_W{1'b0}}};
      cnt_d = CNT_W'(1);
    end else if (cnt_q != '0) begin
      sh_d  = sh_q << 8;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_valid_o = (cnt_q != '0);
  assign out_byte_o  = sh_q[FR_W-1 -: 8];
  assign out_last_o  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/crc_region_check.sv
module crc_region_check #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_last
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic              req_start, req_err;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              crc_done;
  logic [31:0]       crc_val;
  logic              busy_q, busy_d;

  crc_req_parser #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_parser (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_last  (in_last),
    .busy_i   (busy),
    .start_o  (req_start),
    .err_o    (req_err),
    .addr_o   (req_addr),
    .len_o    (req_len)
  );

  crc_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_i       (req_start),
    .addr_i        (req_addr),
    .len_i         (req_len),
    .mem_rd_en_o   (mem_rd_en),
    .mem_addr_o    (mem_addr),
    .mem_rd_data_i (mem_rd_data),
    .done_o        (crc_done),
    .crc_o         (crc_val)
  );

  crc_resp_tx #(.CRC_W(32)) u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_crc_i  (crc_done),
    .crc_i       (crc_val),
    .load_err_i  (req_err),
    .out_valid_o (out_valid),
    .out_byte_o  (out_byte),
    .out_last_o  (out_last)
  );

  always_comb begin
    busy_d = busy_q;
    if (req_start || req_err)      busy_d = 1'b1;
    else if (out_valid && out_last) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) busy_q <= 1'b0;
    else             busy_q <= busy_d;
  end

  assign busy = busy_q | req_start | req_err;
endmodule

// File: rtl/crc_region_check_sva.sv
module crc_region_check_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              out_valid,
  input logic              out_last
);
  // R7
  rd_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R8
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  // R8
  out_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R2
  out_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_last));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && !mem_rd_en && !busy);
    end
  end
endmodule

bind crc_region_check crc_region_check_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/test_crc_region_check.sv
module test_crc_region_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [7:0]  in_byte;
  logic        busy, mem_rd_en, out_valid, out_last;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rd_data, out_byte;

  int errs = 0, checks = 0;
  int rx_n = 0, rd_n = 0, busy_n = 0, busy_late = 0;
  logic [7:0] rx [0:15];
  logic       rx_lst [0:15];
  logic [7:0] fb [0:31];
  logic       prev_last = 1'b0;
  logic       run_mon = 1'b0;

  always #2 clk = ~clk;

  crc_region_check i_crc_region_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last)
  );

  function automatic logic [7:0] mem_val(input logic [31:0] a);
    logic [31:0] h;
    if (a >= 32'h100 && a < 32'h109) return 8'h31 + a[7:0];
    h = a * 32'h9E3779B1;
    return h[31:24] ^ a[7:0];
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] a, input logic [31:0] n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < int'(n); i++) begin
      c = c ^ {24'h0, mem_val(a + i)};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_addr);

  always @(negedge clk) begin
    if (run_mon) begin
      if (prev_last && busy) busy_late++;
      prev_last = out_valid && out_last;
      if (busy) busy_n++;
      if (mem_rd_en) rd_n++;
      if (out_valid && rx_n < 16) begin
        rx[rx_n] = out_byte;
        rx_lst[rx_n] = out_last;
        rx_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_byte = fb[i]; in_last = (i == n - 1);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic build_req(input logic [31:0] a, input logic [31:0] n);
    fb[0] = 8'h02;
    for (int i = 0; i < 4; i++) begin
      fb[1 + i] = a[31 - 8*i -: 8];
      fb[5 + i] = n[31 - 8*i -: 8];
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; rd_n = 0; busy_n = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 20000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_crc_reply(input logic [31:0] exp, input string req);
    check(rx_n == 5, req, rx_n, 5);
    check(rx[0] == 8'h82, "R2 code", rx[0], 8'h82);
    check({rx[1], rx[2], rx[3], rx[4]} == exp, req, {rx[1], rx[2], rx[3], rx[4]}, exp);
    check(rx_lst[4] && !rx_lst[3], "R2 last", {rx_lst[3], rx_lst[4]}, 2'b01);
  endtask

  localparam logic [63:0] VEC [6] = '{
    64'h00007000_00001000, 64'h00000000_00000001, 64'hFFFFFFFE_00000005,
    64'h12345678_00000033, 64'h00008000_00000200, 64'h000E0000_00000040 };

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!out_valid && !mem_rd_en && !busy, "R10 reset",
          {out_valid, mem_rd_en, busy}, 3'b000);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mon = 1'b1;

    // R1 R7 table of regions
    for (int v = 0; v < 6; v++) begin
      clear_mon();
      build_req(VEC[v][63:32], VEC[v][31:0]);
      send_frame(9);
      @(negedge clk);
      check(busy, "R8 busy rise", busy, 1);
      wait_idle();
      check_crc_reply(ref_crc(VEC[v][63:32], VEC[v][31:0]), "R1 crc");
      check(rd_n == int'(VEC[v][31:0]), "R7 read count", rd_n, VEC[v][31:0]);
    end

    // R3 known check value
    clear_mon(); build_req(32'h100, 32'd9); send_frame(9); wait_idle();
    check_crc_reply(32'hCBF43926, "R3 check value");

    // R6 zero length
    clear_mon(); build_req(32'h5000, 32'd0); send_frame(9); wait_idle();
    check_crc_reply(32'h00000000, "R6 empty");
    check(rd_n == 0, "R6 no reads", rd_n, 0);

    // R4 wrong argument counts: 5, 10 and 1 total bytes
    for (int t = 0; t < 3; t++) begin
      int n;
      n = (t == 0) ? 5 : (t == 1) ? 10 : 1;
      clear_mon(); build_req(32'h1000, 32'h10); fb[9] = 8'h00;
      send_frame(n); wait_idle();
      check(rx_n == 1 && rx[0] == 8'hF0 && rx_lst[0], "R4 bad length",
            {rx_n[7:0], rx[0]}, {8'd1, 8'hF0});
      check(rd_n == 0, "R4 no reads", rd_n, 0);
    end

    // R5 other command byte
    clear_mon(); build_req(32'h0, 32'h4); fb[0] = 8'h03; send_frame(9);
    repeat (12) @(negedge clk);
    check(rx_n == 0 && rd_n == 0 && busy_n == 0, "R5 ignored",
          {rx_n[7:0], rd_n[7:0], busy_n[7:0]}, 0);

    // R9 full frame while busy is dropped
    clear_mon(); build_req(32'h200, 32'h40); send_frame(9);
    repeat (4) @(negedge clk);
    build_req(32'h0, 32'h3); send_frame(9); wait_idle();
    check_crc_reply(ref_crc(32'h200, 32'h40), "R9 overlap");
    check(rd_n == 64, "R9 reads", rd_n, 64);

    // R9 frame that opens while busy and closes after it falls
    clear_mon(); build_req(32'h300, 32'h8); send_frame(9);
    for (int i = 0; i < 32; i++) fb[i] = 8'h02;
    send_frame(32); wait_idle();
    check(rx_n == 5, "R9 straddling frame dropped", rx_n, 5);

    // R9 R8 frame ending on the final reply byte, then one just after
    clear_mon(); build_req(32'h400, 32'h2); send_frame(9);
    begin
      int g = 0;
      @(negedge clk);
      while (!(out_valid && out_last) && g < 100) begin @(negedge clk); g++; end
    end
    in_valid = 1'b1; in_byte = 8'h02; in_last = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    wait_idle();
    check(rx_n == 6, "R9 same-cycle frame", rx_n, 6);
    check(rx[5] == 8'hF0, "R9 next frame taken", rx[5], 8'hF0);
    check(busy_late == 0, "R8 busy fall", busy_late, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule